// File: doc/BRIEF.md
# Multi-Lane DLL Enable Sequencer

This block brings up the delay-locked loops of a memory PHY: one master DLL and up to four byte-lane slave DLLs. A single start pulse captures a packed phase word and a bus-width flag. The block then takes the master DLL out of reset in three timed steps. After the master is running, the enabled slave lanes go through the same three steps together.

Each DLL gets a phase field, a disable control and an active-low reset control. At each step every DLL moves between three states. In the armed state, disable is set and reset is active. In the middle state, disable is cleared and reset is still active. In the running state, disable is cleared and reset is released. Each step lasts a whole number of microseconds, converted to clock cycles by a parameter. Lanes that the bus width leaves unused stay armed.

Software or a boot sequencer pulses the start input once the PHY clocks are stable. It then waits for the done pulse before it starts read training.

Top module: `dll_enable_seq`

## Requirements
- R1: After reset every DLL is armed (disable 1, reset_n 0), all phase outputs are 0, and busy and done are 0.
- R2: The master phase output equals bits [21:16] of the phase word captured on an accepted start. It stays constant until the next accepted start.
- R3: Slave lane i (i counted from 0) drives bits [4i+3:4i] of the captured phase word when the lane is enabled, and 0 when it is not.
- R4: A captured wide-bus flag of 1 enables lanes 0 to 3. A flag of 0 enables only lanes 0 and 1.
- R5: A start seen in idle is accepted on that clock edge. From that edge the master is armed for L1 cycles, then in the middle state for L2 cycles, then running. Ln is the step time in microseconds times CLK_PER_US, with step times of 2, 22 and 22 µs.
- R6: Enabled lanes stay armed until the master sequence has finished, that is L1+L2+L3 cycles after the start edge. They are then armed for L1 more cycles, in the middle state for L2 cycles, and running after that.
- R7: All enabled lanes show identical disable and reset values in every cycle.
- R8: Lanes that are not enabled stay armed throughout the sequence and afterwards.
- R9: Busy is high for 2*(L1+L2+L3) cycles from the start edge. Done is high for exactly the one cycle that follows, when every enabled DLL is running.
- R10: A start pulse that arrives while busy is ignored. Changes to the phase word or the bus-width flag while busy have no effect.
- R11: A start after completion re-arms every DLL and runs the full sequence again with the newly captured inputs.
- R12: No DLL ever shows disable set while its reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only in idle |
| phase_word_i | input | PHASE_W | Packed master and lane phases |
| wide_bus_i | input | 1 | 1 selects the wide (four-lane) bus |
| mst_phase_o | output | MST_PH_W | Master DLL phase |
| mst_dis_o | output | 1 | Master DLL disable |
| mst_rst_n_o | output | 1 | Master DLL active-low reset |
| lane_phase_o | output | MAX_LANES*LANE_PH_W | Slave lane phases, lane 0 in the low bits |
| lane_dis_o | output | MAX_LANES | Slave lane disables |
| lane_rst_n_o | output | MAX_LANES | Slave lane active-low resets |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the properties that hold regardless of timing. Unused lanes stay armed. Enabled lanes move in lockstep. No lane leaves the armed state before the master runs. Disable is never set together with a released reset. Done lasts one cycle and finds the master running. The master phase holds while busy.

Only the bench's scenarios can show the exact length of each step and the cycle on which done fires. The same holds for the bit slice each lane receives under both bus widths, and for the fact that a start or an input change during a run leaves that run unchanged. The bench compares every output against an arithmetic model on every cycle of each run.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

   // Command applied to one DLL control register on a clock edge
   typedef enum logic [1:0] {
      DLL_KEEP = 2'd0,
      DLL_ARM  = 2'd1,   // disable set, reset active
      DLL_MID  = 2'd2,   // disable cleared, reset active
      DLL_RUN  = 2'd3    // disable cleared, reset released
   } dll_cmd_e;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_M1   = 3'd1,
      SQ_M2   = 3'd2,
      SQ_M3   = 3'd3,
      SQ_L1   = 3'd4,
      SQ_L2   = 3'd5,
      SQ_L3   = 3'd6
   } seq_st_e;

endpackage

// File: rtl/dll_step_timer.sv
module dll_step_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= len_i - CNT_W'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
   import dll_seq_pkg::*;
#(
   parameter int LEN1 = 4,
   parameter int LEN2 = 44,
   parameter int LEN3 = 44
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   output logic     accept_o,
   output dll_cmd_e mst_cmd_o,
   output dll_cmd_e lane_cmd_o,
   output logic     busy_o,
   output logic     done_o
);
   localparam int LEN_MAX12 = (LEN1 > LEN2) ? LEN1 : LEN2;
   localparam int LEN_MAX   = (LEN_MAX12 > LEN3) ? LEN_MAX12 : LEN3;
   localparam int CNT_W     = $clog2(LEN_MAX + 1);
   localparam logic [CNT_W-1:0] LEN1_C = CNT_W'(LEN1);
   localparam logic [CNT_W-1:0] LEN2_C = CNT_W'(LEN2);
   localparam logic [CNT_W-1:0] LEN3_C = CNT_W'(LEN3);

   seq_st_e          st_q, st_d;
   logic             load;
   logic [CNT_W-1:0] len;
   logic             expired;
   logic             fin;
   logic             done_q;

   dll_step_timer #(.CNT_W(CNT_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .len_i     (len),
      .expired_o (expired)
   );

   always_comb begin
      st_d       = st_q;
      load       = 1'b0;
      len        = LEN1_C;
      mst_cmd_o  = DLL_KEEP;
      lane_cmd_o = DLL_KEEP;
      fin        = 1'b0;
      accept_o   = 1'b0;
      unique case (st_q)
         SQ_IDLE: if (start_i) begin
            st_d = SQ_M1; load = 1'b1; len = LEN1_C;
            mst_cmd_o = DLL_ARM; lane_cmd_o = DLL_ARM; accept_o = 1'b1;
         end
         SQ_M1: if (expired) begin
            st_d = SQ_M2; load = 1'b1; len = LEN2_C; mst_cmd_o = DLL_MID;
         end
         SQ_M2: if (expired) begin
            st_d = SQ_M3; load = 1'b1; len = LEN3_C; mst_cmd_o = DLL_RUN;
         end
         SQ_M3: if (expired) begin
            st_d = SQ_L1; load = 1'b1; len = LEN1_C; lane_cmd_o = DLL_ARM;
         end
         SQ_L1: if (expired) begin
            st_d = SQ_L2; load = 1'b1; len = LEN2_C; lane_cmd_o = DLL_MID;
         end
         SQ_L2: if (expired) begin
            st_d = SQ_L3; load = 1'b1; len = LEN3_C; lane_cmd_o = DLL_RUN;
         end
         SQ_L3: if (expired) begin
            st_d = SQ_IDLE; fin = 1'b1;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= fin;
      end
   end

   assign busy_o = (st_q != SQ_IDLE);
   assign done_o = done_q;
endmodule

// File: rtl/dll_phase_unpack.sv
module dll_phase_unpack #(
   parameter int PHASE_W    = 32,
   parameter int MST_PH_W   = 6,
   parameter int MST_PH_LSB = 16,
   parameter int LANE_PH_W  = 4,
   parameter int MAX_LANES  = 4
) (
   input  logic [PHASE_W-1:0]             word_i,
   input  logic [MAX_LANES-1:0]           en_i,
   output logic [MST_PH_W-1:0]            mst_phase_o,
   output logic [MAX_LANES*LANE_PH_W-1:0] lane_phase_o
);
   assign mst_phase_o = word_i[MST_PH_LSB +: MST_PH_W];

   for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_lane
      assign lane_phase_o[gi*LANE_PH_W +: LANE_PH_W] =
         en_i[gi] ? word_i[gi*LANE_PH_W +: LANE_PH_W] : '0;
   end
endmodule

// File: rtl/dll_ctrl.sv
module dll_ctrl
   import dll_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  dll_cmd_e cmd_i,
   input  logic     hold_i,
   output logic     dis_o,
   output logic     rst_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_o   <= 1'b1;
         rst_n_o <= 1'b0;
      end else if (hold_i) begin
         dis_o   <= 1'b1;
         rst_n_o <= 1'b0;
      end else begin
         unique case (cmd_i)
            DLL_ARM: begin dis_o <= 1'b1; rst_n_o <= 1'b0; end
            DLL_MID: begin dis_o <= 1'b0; rst_n_o <= 1'b0; end
            DLL_RUN: begin dis_o <= 1'b0; rst_n_o <= 1'b1; end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dll_enable_seq.sv
module dll_enable_seq
   import dll_seq_pkg::*;
#(
   parameter int CLK_PER_US   = 100,
   parameter int STEP1_US     = 2,
   parameter int STEP2_US     = 22,
   parameter int STEP3_US     = 22,
   parameter int PHASE_W      = 32,
   parameter int MST_PH_W     = 6,
   parameter int MST_PH_LSB   = 16,
   parameter int LANE_PH_W    = 4,
   parameter int LANES_WIDE   = 4,
   parameter int LANES_NARROW = 2,
   localparam int MAX_LANES   = LANES_WIDE
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [PHASE_W-1:0]             phase_word_i,
   input  logic                           wide_bus_i,
   output logic [MST_PH_W-1:0]            mst_phase_o,
   output logic                           mst_dis_o,
   output logic                           mst_rst_n_o,
   output logic [MAX_LANES*LANE_PH_W-1:0] lane_phase_o,
   output logic [MAX_LANES-1:0]           lane_dis_o,
   output logic [MAX_LANES-1:0]           lane_rst_n_o,
   output logic                           busy_o,
   output logic                           done_o
);
   localparam int LEN1 = STEP1_US * CLK_PER_US;
   localparam int LEN2 = STEP2_US * CLK_PER_US;
   localparam int LEN3 = STEP3_US * CLK_PER_US;

   // elaboration-time parameter checks
   if (LEN1 < 1 || LEN2 < 1 || LEN3 < 1) begin : g_bad_len
      $error("dll_enable_seq: every step must last at least one cycle");
   end
   if (LANES_NARROW < 1 || LANES_NARROW > LANES_WIDE) begin : g_bad_lanes
      $error("dll_enable_seq: narrow lane count out of range");
   end
   if (PHASE_W < MST_PH_LSB + MST_PH_W || PHASE_W < MAX_LANES * LANE_PH_W) begin : g_bad_word
      $error("dll_enable_seq: phase word too narrow for its fields");
   end

   dll_cmd_e               mst_cmd, lane_cmd;
   logic                   accept;
   logic [PHASE_W-1:0]     phase_q;
   logic [MAX_LANES-1:0]   lane_en_q, lane_en_d;

   for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_en
      assign lane_en_d[gi] = wide_bus_i ? 1'b1 : (gi < LANES_NARROW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= '0;
         lane_en_q <= '0;
      end else if (accept) begin
         phase_q   <= phase_word_i;
         lane_en_q <= lane_en_d;
      end
   end

   dll_seq_fsm #(.LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .accept_o   (accept),
      .mst_cmd_o  (mst_cmd),
      .lane_cmd_o (lane_cmd),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   dll_phase_unpack #(
      .PHASE_W    (PHASE_W),
      .MST_PH_W   (MST_PH_W),
      .MST_PH_LSB (MST_PH_LSB),
      .LANE_PH_W  (LANE_PH_W),
      .MAX_LANES  (MAX_LANES)
   ) i_unpack (
      .word_i       (phase_q),
      .en_i         (lane_en_q),
      .mst_phase_o  (mst_phase_o),
      .lane_phase_o (lane_phase_o)
   );

   dll_ctrl i_mst_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (mst_cmd),
      .hold_i  (1'b0),
      .dis_o   (mst_dis_o),
      .rst_n_o (mst_rst_n_o)
   );

   for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_lane
      dll_ctrl i_lane_ctrl (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_i   (lane_cmd),
         .hold_i  (!lane_en_q[gi]),
         .dis_o   (lane_dis_o[gi]),
         .rst_n_o (lane_rst_n_o[gi])
      );
   end
endmodule

// File: rtl/dll_enable_seq_chk.sv
module dll_enable_seq_chk #(
   parameter int MAX_LANES = 4,
   parameter int MST_PH_W  = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [MST_PH_W-1:0]  mst_phase_o,
   input logic                 mst_dis_o,
   input logic                 mst_rst_n_o,
   input logic [MAX_LANES-1:0] lane_dis_o,
   input logic [MAX_LANES-1:0] lane_rst_n_o,
   input logic [MAX_LANES-1:0] lane_en,
   input logic                 busy_o,
   input logic                 done_o
);
   // R12: master never disabled while its reset is released
   a_r12_mst_no_dis_run: assert property (@(posedge clk) disable iff (!rst_n)
      !(mst_dis_o && mst_rst_n_o));

   // R9: done lasts one cycle and finds the master running, sequence idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && mst_rst_n_o && !mst_dis_o));

   // R2: master phase holds while a sequence runs
   a_r2_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mst_phase_o));

   for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_chk
      // R8: unused lanes stay armed
      a_r8_unused_armed: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_en[gi] |-> (lane_dis_o[gi] && !lane_rst_n_o[gi]));
      // R7: enabled lanes match lane 0
      a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
         lane_en[gi] |-> (lane_dis_o[gi] == lane_dis_o[0] &&
                          lane_rst_n_o[gi] == lane_rst_n_o[0]));
      // R6: a lane leaves the armed state only with the master running
      a_r6_after_master: assert property (@(posedge clk) disable iff (!rst_n)
         (!lane_dis_o[gi] || lane_rst_n_o[gi]) |-> (mst_rst_n_o && !mst_dis_o));
      // R12: same rule per lane
      a_r12_lane_no_dis_run: assert property (@(posedge clk) disable iff (!rst_n)
         !(lane_dis_o[gi] && lane_rst_n_o[gi]));
   end
endmodule

bind dll_enable_seq dll_enable_seq_chk #(
   .MAX_LANES (MAX_LANES),
   .MST_PH_W  (MST_PH_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mst_phase_o  (mst_phase_o),
   .mst_dis_o    (mst_dis_o),
   .mst_rst_n_o  (mst_rst_n_o),
   .lane_dis_o   (lane_dis_o),
   .lane_rst_n_o (lane_rst_n_o),
   .lane_en      (lane_en_q),
   .busy_o       (busy_o),
   .done_o       (done_o)
);

// File: tb/test_dll_enable_seq.sv
`timescale 1ns/1ps
module test_dll_enable_seq;
   localparam int CPU = 2;
   localparam int L1 = 2 * CPU;
   localparam int L2 = 22 * CPU;
   localparam int L3 = 22 * CPU;
   localparam int P  = L1 + L2 + L3;
   localparam int NL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] phase_word_i = '0;
   logic        wide_bus_i = 1'b0;
   logic [5:0]  mst_phase_o;
   logic        mst_dis_o, mst_rst_n_o;
   logic [15:0] lane_phase_o;
   logic [3:0]  lane_dis_o, lane_rst_n_o;
   logic        busy_o, done_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dll_enable_seq #(.CLK_PER_US(CPU)) i_dll_enable_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .phase_word_i (phase_word_i), .wide_bus_i (wide_bus_i),
      .mst_phase_o (mst_phase_o), .mst_dis_o (mst_dis_o),
      .mst_rst_n_o (mst_rst_n_o), .lane_phase_o (lane_phase_o),
      .lane_dis_o (lane_dis_o), .lane_rst_n_o (lane_rst_n_o),
      .busy_o (busy_o), .done_o (done_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // step state code: 0 armed, 1 middle, 2 running
   function automatic int mst_state(input int t);
      if (t < L1) return 0;
      if (t < L1 + L2) return 1;
      return 2;
   endfunction

   function automatic int lane_state(input int t);
      if (t < P + L1) return 0;
      if (t < P + L1 + L2) return 1;
      return 2;
   endfunction

   // one full sequence; glitch >= 0 pulses start mid-run (R10)
   task automatic run(input logic [31:0] word, input bit wide, input int glitch);
      int nen;
      nen = wide ? 4 : 2;
      @(negedge clk);
      start_i = 1'b1; phase_word_i = word; wide_bus_i = wide;
      @(posedge clk);
      for (int t = 0; t <= 2 * P + 1; t++) begin
         int ms, ls;
         @(negedge clk);
         if (t == 0) start_i = 1'b0;
         if (t == 5) begin phase_word_i = ~word; wide_bus_i = ~wide; end
         if (glitch >= 0 && t == glitch) start_i = 1'b1;
         if (glitch >= 0 && t == glitch + 1) start_i = 1'b0;
         ms = mst_state(t);
         ls = lane_state(t);
         // R5 master steps, R12 never disabled while running, R11 restart re-arms
         chk(mst_dis_o == (ms == 0) && mst_rst_n_o == (ms == 2), "R5 R11 master step",
             {mst_dis_o, mst_rst_n_o}, {(ms == 0), (ms == 2)});
         chk(!(mst_dis_o && mst_rst_n_o), "R12 master dis+run", 1, 0);
         // R2 master phase, R10 unaffected by input changes
         chk(mst_phase_o == word[21:16], "R2 R10 master phase", mst_phase_o, word[21:16]);
         for (int i = 0; i < NL; i++) begin
            bit en;
            logic [3:0] ep;
            en = (i < nen);
            ep = en ? word[4*i +: 4] : 4'h0;
            // R3 R4 lane phase slice
            chk(lane_phase_o[4*i +: 4] == ep, "R3 R4 lane phase", lane_phase_o[4*i +: 4], ep);
            if (en)  // R6 R7 enabled lanes follow the slave timeline together
               chk(lane_dis_o[i] == (ls == 0) && lane_rst_n_o[i] == (ls == 2),
                   "R6 R7 lane step", {lane_dis_o[i], lane_rst_n_o[i]}, {(ls == 0), (ls == 2)});
            else     // R8 unused lane armed
               chk(lane_dis_o[i] && !lane_rst_n_o[i], "R8 unused lane",
                   {lane_dis_o[i], lane_rst_n_o[i]}, 2);
         end
         // R9 busy window and done pulse
         chk(busy_o == (t < 2 * P), "R9 busy", busy_o, (t < 2 * P));
         chk(done_o == (t == 2 * P), "R9 done", done_o, (t == 2 * P));
      end
      phase_word_i = '0;
   endtask

   initial begin
      logic [31:0] words [6];
      words[0] = 32'h0000_0000;
      words[1] = 32'hFFFF_FFFF;
      words[2] = 32'h003F_0000;
      words[3] = 32'h0015_4321;
      words[4] = 32'h002A_8765;
      words[5] = 32'hA5C3_9E1B;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(mst_dis_o && !mst_rst_n_o, "R1 master armed", {mst_dis_o, mst_rst_n_o}, 2);
      chk(lane_dis_o == 4'hF && lane_rst_n_o == 4'h0, "R1 lanes armed", lane_dis_o, 15);
      chk(mst_phase_o == 0 && lane_phase_o == 0, "R1 phases zero", lane_phase_o, 0);
      chk(!busy_o && !done_o, "R1 idle", {busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o, "R1 idle after release", busy_o, 0);
      // sweep all words under both bus widths, back to back (R11)
      for (int w = 0; w < 6; w++)
         for (int b = 0; b < 2; b++)
            run(words[w] ^ (32'h1111_1111 * w[31:0] * b[31:0]), b[0], -1);
      // R10 start pulses while busy
      run(32'h0023_BEEF, 1'b0, 3);
      run(32'h0031_CAFE, 1'b1, P + 1);
      run(32'h000C_0F0F, 1'b1, 2 * P - 2);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule